// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees an I2C bus that a target has left in a stuck state, most often with SDA held low partway through a byte. When it runs, it takes the two open-drain lines away from the normal I2C engine. It then drives a fixed release pattern: a start condition, nine clock pulses with SDA released, and a stop condition. Every step of the pattern is held for a programmable number of clock cycles. At the end it gives the lines back, resets the engine, and checks whether both lines now read high.

A recovery run starts in one of two ways. Software can request it directly. It also starts on its own when a new transfer is requested while the bus is unavailable, meaning the engine's busy flag is set or either line reads low. In that case the transfer is held pending. When recovery ends, the transfer is released if the bus is clean and dropped if it is not. When the bus is already available, a transfer request passes straight through in the same cycle.

Top module: `i2c_bus_rescue`

## Requirements
- R1: While idle, a `xfer_req` with `bus_busy_in` low and both `scl_in` and `sda_in` high raises `xfer_go` in that same cycle and starts no recovery, unless `start_req` is also high.
- R2: While idle, a recovery run begins at the clock edge that sees `start_req` high, or `xfer_req` high while the bus is unavailable (`bus_busy_in` high, or `scl_in` or `sda_in` low).
- R3: The run drives 24 steps, written as (SCL released, SDA released): (1,1), (1,0), (0,0), then nine pairs of (1,1) and (0,1), then (0,0), (1,0), (1,1). Across the run, SCL is released from low exactly ten times.
- R4: Each step lasts N+1 clock cycles. N is the `delay_cyc` value captured at the starting edge. Changes to `delay_cyc` during a run have no effect, so a run spans 24*(N+1) cycles plus one check cycle.
- R5: An output enable of 1 pulls its line low and 0 releases it. `override_en` is high exactly during the 24 steps, and both enables are 0 whenever it is low, including out of reset.
- R6: `done` and `engine_rst` pulse for exactly one cycle after the last step, with `override_en` already low.
- R7: `fail` is high only in the `done` cycle, and then only if `scl_in` or `sda_in` reads low.
- R8: If the run was started by a transfer request, the `done` cycle raises `xfer_go` on success or `xfer_drop` on failure, never both. A run started only by `start_req` raises neither.
- R9: A `start_req` or `xfer_req` that arrives while a run is in progress is ignored. No second run follows.
- R10: `busy` is high from the cycle after the starting edge through the `done` cycle, and low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Direct request to run a recovery |
| xfer_req | input | 1 | A new transfer wants the bus |
| bus_busy_in | input | 1 | Busy flag from the I2C engine |
| delay_cyc | input | DLY_W | Extra cycles per step (step = value + 1 cycles) |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| override_en | output | 1 | Sequencer owns the lines |
| busy | output | 1 | Recovery in progress |
| done | output | 1 | One-cycle end-of-recovery pulse |
| fail | output | 1 | A line was still low at the final check |
| engine_rst | output | 1 | Reset pulse to the I2C engine |
| xfer_go | output | 1 | Pending or direct transfer may proceed |
| xfer_drop | output | 1 | Pending transfer is dropped |

## Verification
The assertions take for granted that the line inputs reflect a wired-AND of this block's enables with whatever the target does. They also assume that requests and the delay value are synchronous and stable around each clock edge. The bench models the bus as such a wired-AND, with a target that holds SDA or SCL low and releases SDA only after a chosen number of SCL rising edges. It changes every input shortly after a rising edge, so the block never sees a line or request that moves at the edge itself.

// File: rtl/i2c_rescue_pkg.sv
package i2c_rescue_pkg;

  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_RUN   = 2'd1,
    RS_CHECK = 2'd2
  } rescue_state_t;

  // Number of steps in a run for a given count of clock pulses.
  function automatic int rescue_steps(input int pulses);
    return 3 + 2 * pulses + 3;
  endfunction

  // Line release pattern for a step: {scl_release, sda_release}.
  function automatic logic [1:0] step_lines(input int idx, input int pulses);
    int k;
    logic [1:0] r;
    k = idx - 3;
    if (idx == 0)                    r = 2'b11;
    else if (idx == 1)               r = 2'b10;
    else if (idx == 2)               r = 2'b00;
    else if (k < 2 * pulses)         r = (k % 2 == 0) ? 2'b11 : 2'b01;
    else if (k == 2 * pulses)        r = 2'b00;
    else if (k == 2 * pulses + 1)    r = 2'b10;
    else                             r = 2'b11;
    return r;
  endfunction

endpackage

// File: rtl/i2c_rescue_timer.sv
module i2c_rescue_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [DLY_W-1:0] limit,
  output logic             step_end
);
  logic [DLY_W-1:0] cnt;

  assign step_end = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (load || step_end) cnt <= '0;
    else if (run)              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_rescue_stepper.sv
module i2c_rescue_stepper
  import i2c_rescue_pkg::*;
#(
  parameter int PULSES = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       adv,
  output logic       last,
  output logic [1:0] lines
);
  localparam int TOTAL = rescue_steps(PULSES);
  localparam int SW    = $clog2(TOTAL);

  logic [SW-1:0] idx;

  assign last  = (idx == SW'(TOTAL - 1));
  assign lines = step_lines(int'(idx), PULSES);

  always_ff @(posedge clk) begin
    if (!rst_n)            idx <= '0;
    else if (load)         idx <= '0;
    else if (adv && !last) idx <= idx + 1'b1;
  end
endmodule

// File: rtl/i2c_bus_rescue.sv
module i2c_bus_rescue
  import i2c_rescue_pkg::*;
#(
  parameter int DLY_W  = 8,
  parameter int PULSES = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             xfer_req,
  input  logic             bus_busy_in,
  input  logic [DLY_W-1:0] delay_cyc,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             override_en,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic             engine_rst,
  output logic             xfer_go,
  output logic             xfer_drop
);
  rescue_state_t    st;
  logic [DLY_W-1:0] dly_q;
  logic             pend_q;

  // Named internal events
  logic       bus_ok;
  logic       trigger;
  logic       step_end;
  logic       last_step;
  logic [1:0] rel;
  logic       in_run;
  logic       in_check;
  logic       lines_high;

  assign bus_ok     = !bus_busy_in && scl_in && sda_in;
  assign in_run     = (st == RS_RUN);
  assign in_check   = (st == RS_CHECK);
  assign trigger    = (st == RS_IDLE) && (start_req || (xfer_req && !bus_ok));
  assign lines_high = scl_in && sda_in;

  i2c_rescue_timer #(.DLY_W(DLY_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (trigger),
    .run      (in_run),
    .limit    (dly_q),
    .step_end (step_end)
  );

  i2c_rescue_stepper #(.PULSES(PULSES)) u_step (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (trigger),
    .adv   (step_end),
    .last  (last_step),
    .lines (rel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= RS_IDLE;
      dly_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      unique case (st)
        RS_IDLE: if (trigger) begin
          st     <= RS_RUN;
          dly_q  <= delay_cyc;
          pend_q <= xfer_req;
        end
        RS_RUN:   if (step_end && last_step) st <= RS_CHECK;
        RS_CHECK: st <= RS_IDLE;
        default:  st <= RS_IDLE;
      endcase
    end
  end

  assign override_en = in_run;
  assign scl_oe      = in_run && !rel[1];
  assign sda_oe      = in_run && !rel[0];
  assign busy        = in_run || in_check;
  assign done        = in_check;
  assign engine_rst  = in_check;
  assign fail        = in_check && !lines_high;
  assign xfer_go     = ((st == RS_IDLE) && xfer_req && bus_ok && !start_req)
                     || (in_check && pend_q && lines_high);
  assign xfer_drop   = in_check && pend_q && !lines_high;
endmodule

// File: rtl/i2c_rescue_chk.sv
module i2c_rescue_chk #(
  parameter int PULSES = 9
) (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic sda_oe,
  input logic override_en,
  input logic busy,
  input logic done,
  input logic fail,
  input logic xfer_go,
  input logic xfer_drop
);
  logic       scl_oe_prev;
  logic [7:0] scl_rel_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_oe_prev <= 1'b0;
      scl_rel_cnt <= '0;
    end else begin
      scl_oe_prev <= scl_oe;
      if (!busy)                    scl_rel_cnt <= '0;
      else if (scl_oe_prev && !scl_oe) scl_rel_cnt <= scl_rel_cnt + 1'b1;
    end
  end

  p_oe_needs_ovr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !override_en |-> (!scl_oe && !sda_oe));
  p_ovr_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    override_en |-> busy);
  p_busy_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done) |=> !busy);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !override_en);
  p_fail_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);
  p_outcome_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_go && xfer_drop));
  p_drop_means_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_drop |-> fail);
  p_pulse_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (scl_rel_cnt == 8'(PULSES + 1)));
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

bind i2c_bus_rescue i2c_rescue_chk #(.PULSES(PULSES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_oe      (scl_oe),
  .sda_oe      (sda_oe),
  .override_en (override_en),
  .busy        (busy),
  .done        (done),
  .fail        (fail),
  .xfer_go     (xfer_go),
  .xfer_drop   (xfer_drop)
);

// File: tb/i2c_bus_rescue_tb.sv
module i2c_bus_rescue_tb;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0, xfer_req = 1'b0, bus_busy_in = 1'b0;
  logic [DW-1:0] delay_cyc = '0;
  logic scl_oe, sda_oe, override_en, busy, done, fail, engine_rst, xfer_go, xfer_drop;

  // Bus environment: wired-AND with a target that may hold lines low
  logic scl_hold = 1'b0;
  logic sda_stuck = 1'b0;
  int   hold_rises = 0;
  int   rise_cnt = 0;
  logic scl_prev = 1'b1;
  logic scl_line, sda_line;
  assign scl_line = !scl_oe && !scl_hold;
  assign sda_line = !sda_oe && !(sda_stuck && (rise_cnt < hold_rises));

  int pass_cnt = 0, fail_cnt = 0, cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  i2c_bus_rescue #(.DLY_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .xfer_req(xfer_req),
    .bus_busy_in(bus_busy_in), .delay_cyc(delay_cyc),
    .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .override_en(override_en),
    .busy(busy), .done(done), .fail(fail), .engine_rst(engine_rst),
    .xfer_go(xfer_go), .xfer_drop(xfer_drop)
  );

  always @(posedge clk) begin
    scl_prev <= scl_line;
    if (!sda_stuck) rise_cnt <= 0;
    else if (scl_line && !scl_prev) rise_cnt <= rise_cnt + 1;
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    if (act === exp) pass_cnt++;
    else begin
      fail_cnt++;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    if (act == exp) pass_cnt++;
    else begin
      fail_cnt++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference model: queue of per-cycle expected line codes; 4 marks the check cycle
  int  q[$];
  bit  m_pend;

  task automatic push_step(input bit s, input bit d, input int n);
    for (int c = 0; c <= n; c++) q.push_back({s, d});
  endtask

  always @(posedge clk) begin
    if (!rst_n) q.delete();
    else if (q.size() == 0) begin
      if (start_req || (xfer_req && !(!bus_busy_in && scl_line && sda_line))) begin
        int n;
        n = int'(delay_cyc);
        push_step(1, 1, n); push_step(1, 0, n); push_step(0, 0, n);
        for (int p = 0; p < 9; p++) begin push_step(1, 1, n); push_step(0, 1, n); end
        push_step(0, 0, n); push_step(1, 0, n); push_step(1, 1, n);
        q.push_back(4);
        m_pend = xfer_req;
      end
    end else void'(q.pop_front());
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit e_busy, e_ovr, e_so, e_do, e_done, e_fail, e_go, e_drop;
      bit ok;
      ok = !bus_busy_in && scl_line && sda_line;
      if (q.size() == 0) begin
        {e_busy, e_ovr, e_so, e_do, e_done, e_fail, e_drop} = '0;
        e_go = xfer_req && ok && !start_req;
      end else if (q[0] == 4) begin
        e_busy = 1; e_ovr = 0; e_so = 0; e_do = 0; e_done = 1;
        e_fail = !(scl_line && sda_line);
        e_go = m_pend && !e_fail; e_drop = m_pend && e_fail;
      end else begin
        e_busy = 1; e_ovr = 1; e_done = 0; e_fail = 0; e_go = 0; e_drop = 0;
        e_so = !q[0][1]; e_do = !q[0][0];
      end
      chk("R10 busy", busy, e_busy);
      chk("R5 override_en", override_en, e_ovr);
      chk("R3 scl_oe", scl_oe, e_so);
      chk("R3 sda_oe", sda_oe, e_do);
      chk("R6 done", done, e_done);
      chk("R6 engine_rst", engine_rst, e_done);
      chk("R7 fail", fail, e_fail);
      chk("R8 xfer_go", xfer_go, e_go);
      chk("R8 xfer_drop", xfer_drop, e_drop);
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      fail_cnt++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
      $finish;
    end
  end

  task automatic pulse_start();
    @(posedge clk); #2 start_req = 1'b1;
    @(posedge clk); #2 start_req = 1'b0;
  endtask

  task automatic pulse_xfer();
    @(posedge clk); #2 xfer_req = 1'b1;
    @(posedge clk); #2 xfer_req = 1'b0;
  endtask

  // Count busy cycles of a run that has just been triggered; returns fail/drop/go seen on done
  task automatic measure(output int n, output bit f, output bit g, output bit d);
    do @(negedge clk); while (!busy);
    n = 0;
    forever begin
      n++;
      if (done) begin f = fail; g = xfer_go; d = xfer_drop; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    int n; bit f, g, d;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk("R5 reset scl_oe", scl_oe, 1'b0);
    chk("R5 reset sda_oe", sda_oe, 1'b0);
    chk("R10 reset busy", busy, 1'b0);

    // R1: clean bus passes a transfer straight through
    @(posedge clk); #2 xfer_req = 1'b1;
    @(negedge clk); chk("R1 direct xfer_go", xfer_go, 1'b1);
    @(posedge clk); #2 xfer_req = 1'b0;
    @(negedge clk); chk("R1 no recovery", busy, 1'b0);

    // R4: step length with several delays
    delay_cyc = 8'd2; pulse_start(); measure(n, f, g, d);
    chk_int("R4 run length N=2", n, 24 * 3 + 1);
    chk("R7 clean bus no fail", f, 1'b0);
    chk("R8 manual no go", g, 1'b0);
    delay_cyc = 8'd0; pulse_start(); measure(n, f, g, d);
    chk_int("R4 run length N=0", n, 25);

    // R4: delay changed mid-run is ignored
    delay_cyc = 8'd3; pulse_start();
    repeat (5) @(posedge clk); #2 delay_cyc = 8'd7;
    measure(n, f, g, d);
    chk_int("R4 latched delay", n, 24 * 4 + 1 - 5);

    // R9: requests during a run are ignored
    delay_cyc = 8'd1; pulse_start();
    repeat (10) @(posedge clk);
    #2 start_req = 1'b1; xfer_req = 1'b1;
    @(posedge clk); #2 start_req = 1'b0; xfer_req = 1'b0;
    measure(n, f, g, d);
    chk("R9 no pending from ignored xfer", g, 1'b0);
    @(negedge clk); chk("R9 no second run", busy, 1'b0);
    @(negedge clk); chk("R9 still idle", busy, 1'b0);

    // R2/R8: SDA held by target, released after 3 SCL rises
    sda_stuck = 1'b1; hold_rises = 3;
    @(posedge clk);
    pulse_xfer(); measure(n, f, g, d);
    chk("R8 recovered go", g, 1'b1);
    chk("R8 recovered no drop", d, 1'b0);
    sda_stuck = 1'b0;

    // R2: busy flag triggers recovery
    @(posedge clk); #2 bus_busy_in = 1'b1; xfer_req = 1'b1;
    @(posedge clk); #2 bus_busy_in = 1'b0; xfer_req = 1'b0;
    measure(n, f, g, d);
    chk("R2 busy flag run go", g, 1'b1);

    // R2: SCL low triggers recovery
    @(posedge clk); #2 scl_hold = 1'b1; xfer_req = 1'b1;
    @(posedge clk); #2 scl_hold = 1'b0; xfer_req = 1'b0;
    measure(n, f, g, d);
    chk("R2 scl low run go", g, 1'b1);

    // R7/R8: permanently stuck SDA
    sda_stuck = 1'b1; hold_rises = 1000;
    pulse_xfer(); measure(n, f, g, d);
    chk("R7 stuck fail", f, 1'b1);
    chk("R8 stuck drop", d, 1'b1);
    chk("R8 stuck no go", g, 1'b0);
    pulse_start(); measure(n, f, g, d);
    chk("R7 manual stuck fail", f, 1'b1);
    chk("R8 manual no drop", d, 1'b0);
    sda_stuck = 1'b0;

    repeat (4) @(posedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
    $finish;
  end
endmodule